// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node directory for a small distributed shared-memory system. Every memory block it owns has a directory entry and a data word. The entry holds a three-valued state (uncached, shared, exclusive) and a sharer vector with one bit per node. Node caches send it read misses, write misses and data write-backs. In reply it sends invalidations, fetch requests to a remote owner, and data replies to the requester, and it keeps the home copy of each block current.

Each request passes through a fixed directory processing delay of `DIR_LAT` cycles before the controller acts on it. When a block is held exclusive, the owner's data always comes back to the home node and is written into home memory first. Only then is it forwarded to the requester. The controller handles one transaction at a time, so a block never has two transactions open. All outbound traffic uses a single valid/ready message port. Data returned by an owner arrives on a separate one-cycle strobe.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is uncached with an empty sharer vector and every data word is zero, `req_ready_o` is 1 and `msg_valid_o` is 0.
- R2: When a request is accepted (`req_valid_i` and `req_ready_o` high at a clock edge), its first outbound message becomes valid exactly `DIR_LAT` cycles after that edge.
- R3: A read miss (`req_type_i`=0) to an uncached or shared block produces one data reply (`msg_type_o`=3) to the requester carrying the home data. It adds the requester to the sharer vector, and the entry becomes shared.
- R4: A write miss (`req_type_i`=1) to an uncached block produces a data reply with the home data. The entry becomes exclusive with the requester as sole owner.
- R5: A write miss to a shared block first sends an invalidate (`msg_type_o`=0) to each sharer other than the requester, in ascending node index. It then sends the data reply. Afterwards the requester is the sole exclusive owner.
- R6: A read miss to an exclusive block sends a fetch (`msg_type_o`=1) to the owner and waits for `fetch_valid_i`. It writes the returned word into home memory and then replies with that word. Afterwards the entry is shared by the old owner and the requester.
- R7: A write miss to an exclusive block sends a fetch-and-invalidate (`msg_type_o`=2) to the owner and writes the returned word into home memory. It then replies with that word, and the requester becomes the sole exclusive owner.
- R8: A write-back (`req_type_i`=2) from the owner of an exclusive block stores `req_data_i` into home memory and returns the entry to uncached with no sharers. It sends no message.
- R9: A write-back to a block that is not exclusive, or from a node that is not its owner, changes neither memory nor directory and sends no message.
- R10: Only one transaction is open at a time. `req_ready_o` stays low from acceptance until the data reply is taken, or until a write-back finishes. `fetch_valid_i` is ignored unless an owner's data is awaited.
- R11: While `msg_valid_o` is high and `msg_ready_i` is low, the message type, node, block and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request taken on this edge |
| req_type_i | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_node_i | input | NODE_W | Requesting node |
| req_blk_i | input | BLK_W | Block index |
| req_data_i | input | DATA_W | Write-back data |
| msg_valid_o | output | 1 | Outbound message present |
| msg_ready_i | input | 1 | Network takes the message |
| msg_type_o | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| msg_node_o | output | NODE_W | Destination node |
| msg_blk_o | output | BLK_W | Block of the message |
| msg_data_o | output | DATA_W | Reply data (zero for control messages) |
| fetch_valid_i | input | 1 | Owner data returning, one cycle |
| fetch_data_i | input | DATA_W | Owner data word |

## Verification
The bench builds the controller with four nodes, four blocks, 16-bit data and a three-cycle directory delay. With only four blocks, random traffic keeps hitting the same entries. That drives each block through every state change, including invalidation fan-outs to up to three sharers and fetches from owners. The short delay keeps runs brief, and the latency check still measures a delay longer than one register stage. Random back-pressure on `msg_ready_i` exercises the message-hold rule during invalidation bursts as well as on replies.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {D_UNC = 2'd0, D_SHR = 2'd1, D_EXC = 2'd2} dstate_e;
  typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_WRITE = 2'd1, RQ_WBACK = 2'd2} req_e;
  typedef enum logic [1:0] {MS_INV = 2'd0, MS_FETCH = 2'd1, MS_FETCH_INV = 2'd2, MS_DATA = 2'd3} msg_e;
  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_INV, S_FETCH, S_WAITD, S_REPLY} fsm_e;
endpackage

// File: rtl/dir_table.sv
module dir_table
  import dir_pkg::*;
#(
  parameter int N_BLOCKS = 16,
  parameter int N_NODES  = 8,
  localparam int BLK_W   = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BLK_W-1:0]   rd_blk_i,
  output dstate_e            rd_state_o,
  output logic [N_NODES-1:0] rd_sharers_o,
  input  logic               wr_en_i,
  input  logic [BLK_W-1:0]   wr_blk_i,
  input  dstate_e            wr_state_i,
  input  logic [N_NODES-1:0] wr_sharers_i
);
  dstate_e            st_q [N_BLOCKS];
  logic [N_NODES-1:0] sh_q [N_BLOCKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_BLOCKS; i++) begin
        st_q[i] <= D_UNC;
        sh_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      st_q[wr_blk_i] <= wr_state_i;
      sh_q[wr_blk_i] <= wr_sharers_i;
    end
  end

  assign rd_state_o   = st_q[rd_blk_i];
  assign rd_sharers_o = sh_q[rd_blk_i];
endmodule

// File: rtl/dir_mem.sv
module dir_mem #(
  parameter int N_BLOCKS = 16,
  parameter int DATA_W   = 32,
  localparam int BLK_W   = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [BLK_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] mem_q [N_BLOCKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_BLOCKS; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/dir_pick_low.sv
module dir_pick_low #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     oh_o
);
  // lowest set bit wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    oh_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        oh_o  = '0;
        oh_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int N_NODES  = 8,
  parameter int N_BLOCKS = 16,
  parameter int DATA_W   = 32,
  parameter int DIR_LAT  = 5,
  localparam int NODE_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int BLK_W   = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1,
  localparam int CNT_W   = $clog2(DIR_LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_type_i,
  input  logic [NODE_W-1:0] req_node_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [1:0]        msg_type_o,
  output logic [NODE_W-1:0] msg_node_o,
  output logic [BLK_W-1:0]  msg_blk_o,
  output logic [DATA_W-1:0] msg_data_o,
  input  logic              fetch_valid_i,
  input  logic [DATA_W-1:0] fetch_data_i
);
  fsm_e               state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  req_e               typ_q, typ_d;
  logic [NODE_W-1:0]  node_q, node_d;
  logic [BLK_W-1:0]   blk_q, blk_d;
  logic [DATA_W-1:0]  wdata_q, wdata_d;
  logic [N_NODES-1:0] pend_q, pend_d;
  logic               mv_q, mv_d;
  msg_e               mt_q, mt_d;
  logic [NODE_W-1:0]  mn_q, mn_d;
  logic [DATA_W-1:0]  md_q, md_d;

  dstate_e            ent_st;
  logic [N_NODES-1:0] ent_sh;
  logic               tbl_we;
  dstate_e            tbl_st_w;
  logic [N_NODES-1:0] tbl_sh_w;
  logic [DATA_W-1:0]  mem_rd;
  logic               mem_we;
  logic [DATA_W-1:0]  mem_wd;

  logic [N_NODES-1:0] req_bit, inv_vec, inv_oh, own_oh;
  logic               inv_any, own_any, hs;
  logic [NODE_W-1:0]  inv_idx, own_idx;

  dir_table #(.N_BLOCKS(N_BLOCKS), .N_NODES(N_NODES)) u_table (
    .clk_i, .rst_ni,
    .rd_blk_i(blk_q), .rd_state_o(ent_st), .rd_sharers_o(ent_sh),
    .wr_en_i(tbl_we), .wr_blk_i(blk_q), .wr_state_i(tbl_st_w), .wr_sharers_i(tbl_sh_w)
  );

  dir_mem #(.N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni,
    .rd_addr_i(blk_q), .rd_data_o(mem_rd),
    .wr_en_i(mem_we), .wr_addr_i(blk_q), .wr_data_i(mem_wd)
  );

  always_comb begin
    for (int i = 0; i < N_NODES; i++) req_bit[i] = (node_q == NODE_W'(i));
  end

  // first invalidate comes from the entry, the rest from the pending vector
  assign inv_vec = (state_q == S_LOOK) ? (ent_sh & ~req_bit) : pend_q;

  dir_pick_low #(.N(N_NODES)) u_pick_inv (
    .vec_i(inv_vec), .any_o(inv_any), .idx_o(inv_idx), .oh_o(inv_oh)
  );

  dir_pick_low #(.N(N_NODES)) u_pick_own (
    .vec_i(ent_sh), .any_o(own_any), .idx_o(own_idx), .oh_o(own_oh)
  );

  assign hs = mv_q && msg_ready_i;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    typ_d    = typ_q;
    node_d   = node_q;
    blk_d    = blk_q;
    wdata_d  = wdata_q;
    pend_d   = pend_q;
    mv_d     = mv_q;
    mt_d     = mt_q;
    mn_d     = mn_q;
    md_d     = md_q;
    tbl_we   = 1'b0;
    tbl_st_w = ent_st;
    tbl_sh_w = ent_sh;
    mem_we   = 1'b0;
    mem_wd   = wdata_q;

    unique case (state_q)
      S_IDLE: begin
        if (req_valid_i) begin
          typ_d   = req_e'(req_type_i);
          node_d  = req_node_i;
          blk_d   = req_blk_i;
          wdata_d = req_data_i;
          cnt_d   = CNT_W'(DIR_LAT - 1);
          state_d = S_LOOK;
        end
      end

      S_LOOK: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          state_d = S_IDLE;
          unique case (typ_q)
            RQ_READ: begin
              if (ent_st == D_EXC && own_any) begin
                mv_d = 1'b1; mt_d = MS_FETCH; mn_d = own_idx; md_d = '0;
                state_d = S_FETCH;
              end else begin
                tbl_we   = 1'b1;
                tbl_st_w = D_SHR;
                tbl_sh_w = ent_sh | req_bit;
                mv_d = 1'b1; mt_d = MS_DATA; mn_d = node_q; md_d = mem_rd;
                state_d = S_REPLY;
              end
            end
            RQ_WRITE: begin
              if (ent_st == D_EXC && own_any) begin
                mv_d = 1'b1; mt_d = MS_FETCH_INV; mn_d = own_idx; md_d = '0;
                state_d = S_FETCH;
              end else begin
                tbl_we   = 1'b1;
                tbl_st_w = D_EXC;
                tbl_sh_w = req_bit;
                mv_d = 1'b1;
                if (inv_any) begin
                  mt_d = MS_INV; mn_d = inv_idx; md_d = '0;
                  pend_d  = inv_vec & ~inv_oh;
                  state_d = S_INV;
                end else begin
                  mt_d = MS_DATA; mn_d = node_q; md_d = mem_rd;
                  state_d = S_REPLY;
                end
              end
            end
            RQ_WBACK: begin
              // only the recorded owner may return the block
              if (ent_st == D_EXC && ent_sh == req_bit) begin
                tbl_we   = 1'b1;
                tbl_st_w = D_UNC;
                tbl_sh_w = '0;
                mem_we   = 1'b1;
                mem_wd   = wdata_q;
              end
            end
            default: ;
          endcase
        end
      end

      S_INV: begin
        if (hs) begin
          if (inv_any) begin
            mt_d = MS_INV; mn_d = inv_idx; md_d = '0;
            pend_d = inv_vec & ~inv_oh;
          end else begin
            mt_d = MS_DATA; mn_d = node_q; md_d = mem_rd;
            state_d = S_REPLY;
          end
        end
      end

      S_FETCH: begin
        if (hs) begin
          mv_d    = 1'b0;
          state_d = S_WAITD;
        end
      end

      S_WAITD: begin
        if (fetch_valid_i) begin
          mem_we   = 1'b1;
          mem_wd   = fetch_data_i;
          tbl_we   = 1'b1;
          if (typ_q == RQ_READ) begin
            tbl_st_w = D_SHR;
            tbl_sh_w = ent_sh | req_bit;
          end else begin
            tbl_st_w = D_EXC;
            tbl_sh_w = req_bit;
          end
          mv_d = 1'b1; mt_d = MS_DATA; mn_d = node_q; md_d = fetch_data_i;
          state_d = S_REPLY;
        end
      end

      S_REPLY: begin
        if (hs) begin
          mv_d    = 1'b0;
          state_d = S_IDLE;
        end
      end

      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      typ_q   <= RQ_READ;
      node_q  <= '0;
      blk_q   <= '0;
      wdata_q <= '0;
      pend_q  <= '0;
      mv_q    <= 1'b0;
      mt_q    <= MS_INV;
      mn_q    <= '0;
      md_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      typ_q   <= typ_d;
      node_q  <= node_d;
      blk_q   <= blk_d;
      wdata_q <= wdata_d;
      pend_q  <= pend_d;
      mv_q    <= mv_d;
      mt_q    <= mt_d;
      mn_q    <= mn_d;
      md_q    <= md_d;
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign msg_valid_o = mv_q;
  assign msg_type_o  = mt_q;
  assign msg_node_o  = mn_q;
  assign msg_blk_o   = blk_q;
  assign msg_data_o  = md_q;
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
  parameter int NODE_W = 3,
  parameter int BLK_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              msg_valid_o,
  input logic              msg_ready_i,
  input logic [1:0]        msg_type_o,
  input logic [NODE_W-1:0] msg_node_o,
  input logic [BLK_W-1:0]  msg_blk_o,
  input logic [DATA_W-1:0] msg_data_o,
  input logic [NODE_W-1:0] node_q
);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_type_o) && $stable(msg_node_o)
      && $stable(msg_blk_o) && $stable(msg_data_o));

  p_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> !req_ready_o);

  p_free_after_reply_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_ready_i && msg_type_o == 2'd3 |=> req_ready_o);

  p_no_self_inv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_type_o == 2'd0 |-> msg_node_o != node_q);

  p_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !msg_valid_o && !req_ready_o);
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.NODE_W(NODE_W), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i), .msg_type_o(msg_type_o),
  .msg_node_o(msg_node_o), .msg_blk_o(msg_blk_o), .msg_data_o(msg_data_o), .node_q(node_q)
);

// File: tb/tb_dir_home_ctrl.sv
module tb_dir_home_ctrl;
  localparam int NN = 4, NB = 4, DW = 16, LAT = 3;
  localparam int NW = 2, BW = 2;
  localparam int UNC = 0, SHR = 1, EXC = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid_i = 0, msg_ready_i = 1, fetch_valid_i = 0;
  logic [1:0] req_type_i = 0;
  logic [NW-1:0] req_node_i = 0;
  logic [BW-1:0] req_blk_i = 0;
  logic [DW-1:0] req_data_i = 0, fetch_data_i = 0;
  logic req_ready_o, msg_valid_o;
  logic [1:0] msg_type_o;
  logic [NW-1:0] msg_node_o;
  logic [BW-1:0] msg_blk_o;
  logic [DW-1:0] msg_data_o;

  always #5 clk = ~clk;

  dir_home_ctrl #(.N_NODES(NN), .N_BLOCKS(NB), .DATA_W(DW), .DIR_LAT(LAT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i, .req_ready_o, .req_type_i, .req_node_i,
    .req_blk_i, .req_data_i, .msg_valid_o, .msg_ready_i, .msg_type_o, .msg_node_o,
    .msg_blk_o, .msg_data_o, .fetch_valid_i, .fetch_data_i
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int m_st [NB];
  logic [NN-1:0] m_sh [NB];
  logic [DW-1:0] m_mem [NB];
  int e_typ [8], e_node [8];
  logic [DW-1:0] e_dat [8];
  string e_r [8];
  int ne;
  logic [DW-1:0] last_data;

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int low_idx(input logic [NN-1:0] v);
    for (int i = 0; i < NN; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic push(input int t, input int n, input logic [DW-1:0] d, input string r);
    e_typ[ne] = t; e_node[ne] = n; e_dat[ne] = d; e_r[ne] = r; ne++;
  endtask

  // model: expected messages and new directory contents
  task automatic model(input int t, input int n, input int b, input logic [DW-1:0] d,
                       input logic [DW-1:0] fd);
    logic [NN-1:0] rb;
    rb = '0; rb[n] = 1'b1;
    ne = 0;
    if (t == 0) begin
      if (m_st[b] == EXC) begin
        push(1, low_idx(m_sh[b]), 0, "R6");
        push(3, n, fd, "R6");
        m_mem[b] = fd; m_sh[b] = m_sh[b] | rb;
      end else begin
        push(3, n, m_mem[b], "R3");
        m_sh[b] = m_sh[b] | rb;
      end
      m_st[b] = SHR;
    end else if (t == 1) begin
      if (m_st[b] == EXC) begin
        push(2, low_idx(m_sh[b]), 0, "R7");
        push(3, n, fd, "R7");
        m_mem[b] = fd;
      end else if (m_st[b] == SHR) begin
        for (int i = 0; i < NN; i++) if (m_sh[b][i] && i != n) push(0, i, 0, "R5");
        push(3, n, m_mem[b], "R5");
      end else begin
        push(3, n, m_mem[b], "R4");
      end
      m_st[b] = EXC; m_sh[b] = rb;
    end else begin
      if (m_st[b] == EXC && m_sh[b] == rb) begin
        m_mem[b] = d; m_sh[b] = '0; m_st[b] = UNC;
      end
    end
  endtask

  task automatic run_req(input int t, input int n, input int b, input logic [DW-1:0] d,
                         input logic [DW-1:0] fd);
    int lat, w, seen;
    logic [DW+NW+BW+2:0] snap;
    model(t, n, b, d, fd);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1; req_type_i = 2'(t); req_node_i = NW'(n); req_blk_i = BW'(b); req_data_i = d;
    @(negedge clk);
    req_valid_i = 0;
    if (ne == 0) begin
      seen = 0;
      while (!req_ready_o) begin
        if (msg_valid_o) seen++;
        @(negedge clk);
      end
      chk(seen == 0, (t == 2) ? "R8/R9 no message" : "R9", seen, 0);
      return;
    end
    lat = 0;
    while (!msg_valid_o && lat < 100) begin lat++; @(negedge clk); end
    chk(lat == LAT, "R2 latency", lat, LAT);
    chk(!req_ready_o, "R10 busy", req_ready_o, 0);
    for (int k = 0; k < ne; k++) begin
      w = 0;
      forever begin
        msg_ready_i = ($urandom_range(0, 3) != 0);
        if (msg_valid_o && msg_ready_i) break;
        snap = {msg_valid_o, msg_type_o, msg_node_o, msg_blk_o, msg_data_o};
        @(negedge clk);
        if (snap[DW+NW+BW+2])
          chk({msg_valid_o, msg_type_o, msg_node_o, msg_blk_o, msg_data_o} == snap, "R11 hold",
              {msg_valid_o, msg_type_o, msg_node_o, msg_blk_o, msg_data_o}, snap);
        if (++w > 200) break;
      end
      chk(msg_type_o == 2'(e_typ[k]), e_r[k], msg_type_o, e_typ[k]);
      chk(msg_node_o == NW'(e_node[k]) && msg_blk_o == BW'(b), e_r[k],
          {msg_node_o, msg_blk_o}, {NW'(e_node[k]), BW'(b)});
      if (e_typ[k] == 3) begin
        chk(msg_data_o == e_dat[k], e_r[k], msg_data_o, e_dat[k]);
        last_data = msg_data_o;
      end
      @(negedge clk);
      msg_ready_i = 1;
      if (e_typ[k] == 1 || e_typ[k] == 2) begin
        fetch_valid_i = 1; fetch_data_i = fd;
        @(negedge clk);
        fetch_valid_i = 0;
      end
    end
    while (!req_ready_o) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NB; i++) begin m_st[i] = UNC; m_sh[i] = '0; m_mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1 && msg_valid_o == 0, "R1 reset ports", {req_ready_o, msg_valid_o}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready_o == 1 && msg_valid_o == 0, "R1 idle", {req_ready_o, msg_valid_o}, 2'b10);
    // directed corner cases
    run_req(0, 0, 0, 0, 0);
    chk(last_data == 0, "R1 zero memory", last_data, 0);
    run_req(0, 2, 0, 0, 0);                // R3 second sharer
    run_req(1, 1, 0, 0, 0);                // R5 invalidates 0 then 2
    run_req(0, 3, 0, 0, 16'h1111);         // R6 fetch from owner 1
    chk(last_data == 16'h1111, "R6 forwarded", last_data, 16'h1111);
    run_req(1, 0, 0, 0, 0);                // R5 invalidates 1 then 3
    run_req(1, 2, 0, 0, 16'h2222);         // R7 fetch-and-invalidate owner 0
    run_req(2, 1, 0, 16'haaaa, 0);         // R9 non-owner write-back
    run_req(2, 2, 0, 16'h3333, 0);         // R8 owner write-back
    run_req(2, 3, 0, 16'h5555, 0);         // R9 write-back to uncached block
    run_req(0, 1, 0, 0, 0);
    chk(last_data == 16'h3333, "R8 memory updated", last_data, 16'h3333);
    chk(last_data != 16'haaaa && last_data != 16'h5555, "R9 ignored write-back", last_data, 16'h3333);
    fetch_valid_i = 1; fetch_data_i = 16'hdead;
    @(negedge clk);
    fetch_valid_i = 0;
    run_req(0, 0, 0, 0, 0);
    chk(last_data == 16'h3333, "R10 stray fetch ignored", last_data, 16'h3333);
    run_req(1, 3, 1, 0, 0);                // R4 uncached write miss
    run_req(0, 0, 1, 0, 16'h4444);
    // random traffic
    for (int i = 0; i < 300; i++) begin
      int t, n, b;
      logic [NN-1:0] rb;
      t = $urandom_range(0, 2); n = $urandom_range(0, NN - 1); b = $urandom_range(0, NB - 1);
      rb = '0; rb[n] = 1'b1;
      if (m_st[b] == EXC && m_sh[b] == rb && t != 2) t = 2;
      run_req(t, n, b, 16'($urandom), 16'($urandom));
    end
    summary();
  end
endmodule